// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the memory-side control levels and address bus of an asynchronous SRAM port. It recognises a hidden command carried inside ordinary read traffic. A command is five reads at fixed addresses in a fixed order, followed by a sixth read whose address chooses one of four operations: save the array to nonvolatile cells, restore the array from them, turn the automatic power-loss save off, or turn it back on. Any access that does not fit the pattern drops the partial match, so normal traffic never triggers a command by accident.

All inputs are sampled on the system clock. An access is counted on the clock edge at which a strobe is first seen asserted: the chip select going active, or, while the chip is already selected, the output enable or the write enable going active. When the sixth read matches, the block raises a one-cycle command pulse together with a 2-bit operation code. Carrying out the operation is the job of a separate controller.

Top module: `seqcmd_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cmd_valid` is 0 and `cmd_code` is 0. Reset returns the match to idle, so an earlier partial sequence does not carry over.
- R2: An access is counted in a sampled cycle where `chip_sel_n` is 0 and one of these holds: `chip_sel_n` was 1 in the previous sample, or `out_en_n` fell from 1 to 0, or `wr_en_n` fell from 1 to 0. `out_en_n` does not need to be low for a read to count.
- R3: Only `addr[13:0]` is compared and `addr[14]` is ignored. The five leading reads must arrive in this order: 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F.
- R4: After the five leading reads, the sixth read selects the code: 0x0FC0 gives code 0 (save), 0x0C63 gives code 1 (restore), 0x03F8 gives code 2 (automatic save off), and 0x07F0 gives code 3 (automatic save on).
- R5: `cmd_valid` is high for exactly one cycle. That cycle follows the clock edge at which the sixth read is sampled. `cmd_code` carries the code during the pulse and is 0 at all other times.
- R6: A read at an address that is not the expected next one aborts the match, and no command follows from it.
- R7: An access with `wr_en_n` low at the strobe aborts the match. This includes a write at a valid sixth address.
- R8: A read of 0x0E38 at any point in the match, including at the sixth position, restarts the match at step one.
- R9: After a command is issued the match is idle, so a single sixth-address read on its own produces no command.
- R10: Levels that are held steady, and address changes made while the strobes are held steady, do not advance or reset the match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_sel_n | input | 1 | Sampled chip select level, active low |
| out_en_n | input | 1 | Sampled output enable level, active low |
| wr_en_n | input | 1 | Sampled write enable level, active low |
| addr | input | 15 | Sampled address bus |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Operation code: 0 save, 1 restore, 2 auto-save off, 3 auto-save on |

## Verification
Each of the four commands is driven once: through chip-select strobes, through output-enable strobes with the top address bit set, and through a mix of both. This shows that both strobe kinds advance the match and that the ignored bit is really ignored. Broken patterns follow: a wrong middle address, a write in the middle, a repeated first address, and a first address in the sixth slot. These separate a plain abort from a restart. Directed cases then hold the strobes steady while the address changes, reset in the middle of a sequence, and send a lone sixth read after a command. These show that only strobe edges count and that the match returns to idle.

// File: rtl/seqcmd_pkg.sv
// Shared constants, types and key tables for the read-sequence command detector.
// Assumes the compared address slice is 14 bits wide and that the prefix and
// opcode keys are all distinct from each other.
package seqcmd_pkg;

    localparam int CMP_W      = 14;
    localparam int PREFIX_LEN = 5;
    localparam int OP_CNT     = 4;
    localparam int OP_W       = $clog2(OP_CNT);
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef enum logic [OP_W-1:0] {
        OP_SAVE     = 2'd0,
        OP_RESTORE  = 2'd1,
        OP_AUTO_OFF = 2'd2,
        OP_AUTO_ON  = 2'd3
    } op_e;

    // Expected address for a given position in the leading part of the sequence.
    function automatic logic [CMP_W-1:0] prefix_key(input int idx);
        case (idx)
            0:       return 14'h0E38;
            1:       return 14'h31C7;
            2:       return 14'h03E0;
            3:       return 14'h3C1F;
            default: return 14'h303F;
        endcase
    endfunction

    // Sixth-position address that selects each operation.
    function automatic logic [CMP_W-1:0] op_key(input op_e op);
        case (op)
            OP_SAVE:     return 14'h0FC0;
            OP_RESTORE:  return 14'h0C63;
            OP_AUTO_OFF: return 14'h03F8;
            default:     return 14'h07F0;
        endcase
    endfunction

endpackage

// File: rtl/seqcmd_strobe.sv
// Turns sampled strobe levels into single-cycle access events.
// An event fires when the chip is selected and a strobe has just become
// active: select itself, output enable, or write enable.
// Assumes the inputs are already synchronous to clk.
module seqcmd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic acc_evt,
    output logic acc_wr
);

    logic sel_prev, rd_prev, wr_prev;

    // Keep the previous sample of each strobe; inactive after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev <= 1'b1;
            rd_prev  <= 1'b1;
            wr_prev  <= 1'b1;
        end else begin
            sel_prev <= sel_n;
            rd_prev  <= rd_n;
            wr_prev  <= wr_n;
        end
    end

    // Classify the current sample as an access edge and as read or write.
    always_comb begin
        acc_evt = !sel_n && (sel_prev || (!rd_n && rd_prev) || (!wr_n && wr_prev));
        acc_wr  = !wr_n;
    end

    // R10: steady levels never produce an access.
    a_r10_steady_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(sel_n) && $stable(rd_n) && $stable(wr_n)) |-> !acc_evt);

    // R2: an access always follows some strobe moving to active.
    a_r2_event_has_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && acc_evt) |-> ($fell(sel_n) || $fell(rd_n) || $fell(wr_n)));

endmodule

// File: rtl/seqcmd_opdec.sv
// Compares the sixth-position address with the opcode keys and reports
// whether it names an operation and which one.
// Assumes the keys are mutually distinct.
module seqcmd_opdec
    import seqcmd_pkg::*;
(
    input  logic [CMP_W-1:0] key,
    output logic             op_hit,
    output op_e              op_sel
);

    logic [OP_CNT-1:0] hitv;

    genvar k;
    generate
        for (k = 0; k < OP_CNT; k++) begin : g_cmp
            assign hitv[k] = (key == op_key(op_e'(k)));
        end
    endgenerate

    // Reduce the hit lines to a flag and an encoded operation.
    always_comb begin
        op_hit = |hitv;
        op_sel = OP_SAVE;
        for (int i = 0; i < OP_CNT; i++) begin
            if (hitv[i]) op_sel = op_e'(i);
        end
    end

endmodule

// File: rtl/seqcmd_track.sv
// Step counter for the read sequence plus the registered command output.
// Advances on reads at the expected prefix address. Restarts on the first
// prefix address, aborts on anything else or on any write, and fires on a
// valid sixth address. Assumes at most one access event per cycle.
module seqcmd_track
    import seqcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_evt,
    input  logic             acc_wr,
    input  logic [CMP_W-1:0] key,
    input  logic             op_hit,
    input  op_e              op_sel,
    output logic             cmd_valid,
    output op_e              cmd_op
);

    localparam int MATCH_N = 1 << STEP_W;
    localparam logic [STEP_W-1:0] STEP_FULL = STEP_W'(PREFIX_LEN);

    logic [STEP_W-1:0]  step_q, step_d;
    logic [MATCH_N-1:0] pmatch;
    logic               fire_d;
    op_e                op_d;

    genvar i;
    generate
        for (i = 0; i < MATCH_N; i++) begin : g_pm
            if (i < PREFIX_LEN) begin : g_real
                assign pmatch[i] = (key == prefix_key(i));
            end else begin : g_pad
                assign pmatch[i] = 1'b0;
            end
        end
    endgenerate

    // Next step and command decision for the current access, if any.
    always_comb begin
        step_d = step_q;
        fire_d = 1'b0;
        op_d   = OP_SAVE;
        if (acc_evt) begin
            if (acc_wr) begin
                step_d = '0;
            end else if (step_q == STEP_FULL && op_hit) begin
                fire_d = 1'b1;
                op_d   = op_sel;
                step_d = '0;
            end else if (pmatch[step_q]) begin
                step_d = step_q + 1'b1;
            end else if (pmatch[0]) begin
                step_d = STEP_W'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    // Register the step and the one-cycle command output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_SAVE;
        end else begin
            step_q    <= step_d;
            cmd_valid <= fire_d;
            cmd_op    <= op_d;
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r5_after_full_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(step_q) == STEP_FULL));

    a_r5_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_op == OP_SAVE));

    a_r7_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_evt && acc_wr) |=> (step_q == '0 && !cmd_valid));

    a_r8_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_evt && !acc_wr && key == prefix_key(0)) |=> (step_q == STEP_W'(1)));

    a_r9_idle_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (step_q == '0));

    a_r10_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_evt |=> $stable(step_q));

    a_r3_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= STEP_FULL);

endmodule

// File: rtl/seqcmd_detector.sv
// Top level of the read-sequence command detector. It samples the memory
// strobes and address, finds the six-read command pattern and issues a
// one-cycle command pulse with its code. Assumes all inputs are synchronous
// to clk and that only the low CMP_W address bits carry the key.
module seqcmd_detector
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_code
);

    logic             acc_evt, acc_wr, op_hit;
    op_e              op_sel, cmd_op;
    logic [CMP_W-1:0] key;

    assign key = addr[CMP_W-1:0];

    generate
        if (ADDR_W > CMP_W) begin : g_hi
            logic addr_hi_unused;
            assign addr_hi_unused = ^addr[ADDR_W-1:CMP_W];
        end
    endgenerate

    seqcmd_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (chip_sel_n),
        .rd_n    (out_en_n),
        .wr_n    (wr_en_n),
        .acc_evt (acc_evt),
        .acc_wr  (acc_wr)
    );

    seqcmd_opdec u_opdec (
        .key    (key),
        .op_hit (op_hit),
        .op_sel (op_sel)
    );

    seqcmd_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_evt   (acc_evt),
        .acc_wr    (acc_wr),
        .key       (key),
        .op_hit    (op_hit),
        .op_sel    (op_sel),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op)
    );

    assign cmd_code = cmd_op;

    // R1: outputs stay quiet while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!cmd_valid || $past(rst_n));
        end
    end

endmodule

// File: tb/seqcmd_detector_bench.sv
// Self-checking bench: a table of access vectors walked by one loop, then
// directed cases for reset, steady levels and post-command behaviour.
module seqcmd_detector_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chip_sel_n, out_en_n, wr_en_n;
    logic [14:0] addr;
    logic        cmd_valid;
    logic [1:0]  cmd_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    seqcmd_detector u_seqcmd_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .addr       (addr),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code)
    );

    // Vector: {oe_strobe, we_n, addr[14:0], exp_valid, exp_code[1:0]}
    localparam int VEC_N = 55;
    localparam logic [19:0] VEC [VEC_N] = '{
        // R3 R4 R5: save via chip-select strobes
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h03E0,1'b0,2'd0}, {1'b0,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b0,1'b1,15'h0FC0,1'b1,2'd0},
        // R2 R3: restore via output-enable strobes, top bit set on some
        {1'b1,1'b1,15'h4E38,1'b0,2'd0}, {1'b1,1'b1,15'h71C7,1'b0,2'd0},
        {1'b1,1'b1,15'h03E0,1'b0,2'd0}, {1'b1,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b1,1'b1,15'h703F,1'b0,2'd0}, {1'b1,1'b1,15'h4C63,1'b1,2'd1},
        // R2 R4: auto-save off, mixed strobes
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b1,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h03E0,1'b0,2'd0}, {1'b1,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b1,1'b1,15'h03F8,1'b1,2'd2},
        // R4: auto-save on
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h03E0,1'b0,2'd0}, {1'b0,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b0,1'b1,15'h07F0,1'b1,2'd3},
        // R6: wrong middle address aborts
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h1234,1'b0,2'd0}, {1'b0,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b0,1'b1,15'h0FC0,1'b0,2'd0},
        // R7: write in the middle aborts
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b0,15'h03E0,1'b0,2'd0}, {1'b0,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b0,1'b1,15'h0FC0,1'b0,2'd0},
        // R8: repeated first address restarts
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h03E0,1'b0,2'd0}, {1'b0,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b0,1'b1,15'h07F0,1'b1,2'd3},
        // R8: first address in the sixth slot restarts
        {1'b0,1'b1,15'h0E38,1'b0,2'd0}, {1'b0,1'b1,15'h31C7,1'b0,2'd0},
        {1'b0,1'b1,15'h03E0,1'b0,2'd0}, {1'b0,1'b1,15'h3C1F,1'b0,2'd0},
        {1'b0,1'b1,15'h303F,1'b0,2'd0}, {1'b0,1'b1,15'h0E38,1'b0,2'd0},
        {1'b0,1'b1,15'h31C7,1'b0,2'd0}, {1'b0,1'b1,15'h03E0,1'b0,2'd0},
        {1'b0,1'b1,15'h3C1F,1'b0,2'd0}, {1'b0,1'b1,15'h303F,1'b0,2'd0},
        {1'b0,1'b1,15'h0C63,1'b1,2'd1}
    };

    task automatic check(input string req, input logic ev, input logic [1:0] ec);
        n_checks++;
        if (cmd_valid !== ev || cmd_code !== ec) begin
            n_fail++;
            $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                     req, cmd_valid, cmd_code, ev, ec);
        end
    endtask

    // Drive levels after a falling edge; return after the next falling edge.
    task automatic drive(input logic s, input logic o, input logic w, input logic [14:0] a);
        chip_sel_n = s;
        out_en_n   = o;
        wr_en_n    = w;
        addr       = a;
        @(negedge clk);
    endtask

    // One access: an idle cycle, then a strobe cycle, both checked.
    task automatic access(input logic oe_mode, input logic we, input logic [14:0] a,
                          input logic ev, input logic [1:0] ec, input string req);
        if (oe_mode) drive(1'b0, 1'b1, 1'b1, a);
        else         drive(1'b1, 1'b1, 1'b1, a);
        check({req, " idle"}, 1'b0, 2'd0);
        if (oe_mode) drive(1'b0, 1'b0, we, a);
        else         drive(1'b0, 1'b1, we, a);
        check(req, ev, ec);
    endtask

    task automatic prefix_ce(input string req);
        access(1'b0, 1'b1, 15'h0E38, 1'b0, 2'd0, req);
        access(1'b0, 1'b1, 15'h31C7, 1'b0, 2'd0, req);
        access(1'b0, 1'b1, 15'h03E0, 1'b0, 2'd0, req);
        access(1'b0, 1'b1, 15'h3C1F, 1'b0, 2'd0, req);
        access(1'b0, 1'b1, 15'h303F, 1'b0, 2'd0, req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        chip_sel_n = 1'b1;
        out_en_n   = 1'b1;
        wr_en_n    = 1'b1;
        addr       = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1 in reset", 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 2'd0);

        // Table walk: R2..R8
        for (int v = 0; v < VEC_N; v++) begin
            access(VEC[v][19], VEC[v][18], VEC[v][17:3], VEC[v][2], VEC[v][1:0],
                   $sformatf("R4 R6 R7 R8 vector %0d", v));
        end

        // R10: steady strobes with a changing address do nothing
        prefix_ce("R10 prefix");
        drive(1'b0, 1'b1, 1'b1, 15'h0E38);
        check("R10 steady addr change", 1'b0, 2'd0);
        drive(1'b0, 1'b1, 1'b1, 15'h0FC0);
        check("R10 steady addr change", 1'b0, 2'd0);
        drive(1'b0, 1'b1, 1'b1, 15'h0FC0);
        check("R10 steady hold", 1'b0, 2'd0);
        access(1'b0, 1'b1, 15'h0FC0, 1'b1, 2'd0, "R10 match kept");

        // R9: a lone sixth read after a command does nothing
        access(1'b0, 1'b1, 15'h0FC0, 1'b0, 2'd0, "R9 lone sixth");

        // R7: a write at a valid sixth address aborts
        prefix_ce("R7 prefix");
        access(1'b0, 1'b0, 15'h0FC0, 1'b0, 2'd0, "R7 write sixth");
        access(1'b0, 1'b1, 15'h0FC0, 1'b0, 2'd0, "R7 after abort");

        // R1: reset mid-sequence clears the match
        prefix_ce("R1 prefix");
        chip_sel_n = 1'b1;
        rst_n      = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset mid", 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 1'b1, 15'h0FC0, 1'b0, 2'd0, "R1 no carry over");

        // R6: unknown sixth address aborts
        prefix_ce("R6 prefix");
        access(1'b0, 1'b1, 15'h0FC1, 1'b0, 2'd0, "R6 bad sixth");
        access(1'b0, 1'b1, 15'h0FC0, 1'b0, 2'd0, "R6 after abort");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule